// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Filtering

This block receives asynchronous serial characters that carry nine bits after the start bit: eight data bits, least significant first, followed by a ninth bit. The line is sampled on a 16x oversampling tick supplied from outside. A three-bit mode input sets what the ninth bit means. It can be an address/data marker, a ninth data bit, or an even parity bit. A separate input selects one or two stop bits.

In address-filter mode, a character is kept only if its ninth bit is 1. Such a character is an address. Characters with a 0 there are data, and they are dropped without a trace. Several receivers sharing one line can therefore sleep through traffic meant for others. Each one wakes on an address character and compares the eight low bits with its own address. The receiver that is addressed switches to ninth-data mode so that it takes in the data characters that follow.

Top module: `uart9_rx`

## Requirements
- R1: After reset, `rbuf_o` is 0x00 and `rb9_o`, `rx_irq_o`, `par_err_o` and `frm_err_o` are all 0.
- R2: A frame is a 0 start bit, eight data bits sent LSB first, a ninth bit, and one or two stop bits at 1. With mode 3'b101, every character is stored: the eight data bits go to `rbuf_o` and the ninth bit goes to `rb9_o`.
- R3: A falling edge on the line is confirmed as a start bit by sampling at the 8th tick. If the line is high at that sample, the receiver returns to idle and stores nothing.
- R4: With mode 3'b100, a character whose ninth bit is 1 is stored and pulses `rx_irq_o`.
- R5: With mode 3'b100, a character whose ninth bit is 0 is discarded. `rbuf_o`, `rb9_o` and both error flags keep their values, and `rx_irq_o` stays low.
- R6: After the mode changes from 3'b100 to 3'b101 between frames, characters whose ninth bit is 0 are stored.
- R7: With mode 3'b111, `par_err_o` is set with the stored character when the ninth bit differs from the XOR of the eight data bits (even parity). Otherwise it is cleared.
- R8: A stop bit sampled at 0 sets `frm_err_o` with the stored character. In modes 3'b101 and 3'b111 the character is still stored. In mode 3'b100 it is discarded.
- R9: When `two_stop_i` is 1, both stop bits are sampled, and a 0 in either one sets `frm_err_o`. The character completes one bit time later than it does with a single stop bit.
- R10: `rx_irq_o` is a single-cycle pulse in the cycle in which the new buffer contents first appear. The buffer never changes without this pulse.
- R11: `par_err_o` is 0 for characters stored in any mode other than 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | One-cycle strobe at 16 times the bit rate |
| mode_i | input | 3 | Ninth-bit meaning: 100 address filter, 101 data, 111 parity |
| two_stop_i | input | 1 | 1 selects two stop bits |
| rbuf_o | output | 8 | Last stored character, low eight bits |
| rb9_o | output | 1 | Ninth bit of the last stored character |
| rx_irq_o | output | 1 | Receive pulse, one cycle per stored character |
| par_err_o | output | 1 | Parity mismatch of the last stored character |
| frm_err_o | output | 1 | Stop-bit error of the last stored character |

## Verification
Count tick k as the tick after which the start bit falls. The start bit is detected on tick k+1 and confirmed on tick k+9. Data bit i is sampled on tick k+25+16i, and the ninth bit on tick k+153. The character completes on the tick edge k+169 with one stop bit, or k+185 with two. The buffer, the flags and the pulse are all expected in the clock cycle after that edge, and the pulse is low again one cycle later. The bench counts ticks itself and moves its expected outputs on exactly those edges. It compares every output on each falling clock edge, so a pulse that comes early, comes late or lasts too long shows up as a mismatch.

// File: rtl/uart9_rx.sv
module uart9_rx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd_i,
  input  logic          tick_i,
  input  logic [2:0]    mode_i,
  input  logic          two_stop_i,
  output logic [DW-1:0] rbuf_o,
  output logic          rb9_o,
  output logic          rx_irq_o,
  output logic          par_err_o,
  output logic          frm_err_o
);

  localparam int CW  = $clog2(OVS);
  localparam int BW  = $clog2(DW + 1);
  localparam int MID = OVS / 2 - 1;
  localparam logic [2:0] MODE_WAKE = 3'b100;
  localparam logic [2:0] MODE_PAR  = 3'b111;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_NINTH, S_STOP1, S_STOP2} st_t;

  st_t           state;
  logic [1:0]    sync_q;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] shreg;
  logic          b9_q, stop_bad;

  wire rx_s    = sync_q[1];
  wire bit_pt  = tick_i && (cnt == CW'(OVS - 1));
  wire done    = bit_pt && ((state == S_STOP1 && !two_stop_i) || state == S_STOP2);
  wire bad_now = stop_bad | ~rx_s;
  wire wake    = (mode_i == MODE_WAKE);
  wire keep    = wake ? (b9_q && !bad_now) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 2'b11;
      state     <= S_IDLE;
      cnt       <= '0;
      bidx      <= '0;
      shreg     <= '0;
      b9_q      <= 1'b0;
      stop_bad  <= 1'b0;
      rbuf_o    <= '0;
      rb9_o     <= 1'b0;
      rx_irq_o  <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
    end else begin
      sync_q   <= {sync_q[0], rxd_i};
      rx_irq_o <= 1'b0;
      case (state)
        S_IDLE:
          if (tick_i && !rx_s) begin
            state <= S_START;
            cnt   <= '0;
          end
        S_START:
          if (tick_i) begin
            if (cnt == CW'(MID)) begin
              cnt      <= '0;
              bidx     <= '0;
              stop_bad <= 1'b0;
              state    <= rx_s ? S_IDLE : S_DATA;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        default:
          if (tick_i) begin
            if (bit_pt) begin
              cnt <= '0;
              case (state)
                S_DATA: begin
                  shreg <= {rx_s, shreg[DW-1:1]};
                  if (bidx == BW'(DW - 1)) state <= S_NINTH;
                  else bidx <= bidx + BW'(1);
                end
                S_NINTH: begin
                  b9_q  <= rx_s;
                  state <= S_STOP1;
                end
                S_STOP1: begin
                  stop_bad <= ~rx_s;
                  state    <= two_stop_i ? S_STOP2 : S_IDLE;
                end
                default: state <= S_IDLE;
              endcase
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
      endcase
      if (done && keep) begin
        rbuf_o    <= shreg;
        rb9_o     <= b9_q;
        rx_irq_o  <= 1'b1;
        par_err_o <= (mode_i == MODE_PAR) && (b9_q != ^shreg);
        frm_err_o <= bad_now;
      end
    end
  end

  // R10
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_o |=> !rx_irq_o);

  // R10
  buf_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rbuf_o != $past(rbuf_o)) || (rb9_o != $past(rb9_o))) |-> rx_irq_o);

  // R3
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START && tick_i && cnt == CW'(MID) && rx_s) |=> state == S_IDLE);

  // R4
  wake_addr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq_o && mode_i == MODE_WAKE) |-> (rb9_o && !frm_err_o));

  // R11
  par_mode_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq_o && mode_i != MODE_PAR) |-> !par_err_o);

endmodule

// File: tb/uart9_rx_tb_top.sv
`timescale 1ns/1ps
module uart9_rx_tb_top;

  logic       clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, tick = 1'b0;
  logic [2:0] mode = 3'b101;
  logic       two = 1'b0;
  logic [7:0] rbuf;
  logic       rb9, irq, pe, fe;

  logic [7:0] e_buf = 8'h00;
  logic       e_b9 = 1'b0, e_irq = 1'b0, e_pe = 1'b0, e_fe = 1'b0;
  string      cur_req = "R1";
  int         n_cmp = 0, n_bad = 0, ph = 0;
  logic       checking = 1'b0;

  uart9_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick_i(tick), .mode_i(mode),
    .two_stop_i(two), .rbuf_o(rbuf), .rb9_o(rb9), .rx_irq_o(irq),
    .par_err_o(pe), .frm_err_o(fe)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    ph   <= (ph + 1) % 4;
    tick <= (ph == 3);
  end

  // every clock: R10 (pulse width/placement), R11 (parity flag) and the scenario's tag
  always @(negedge clk) begin
    if (checking) begin
      n_cmp++;
      if ({rbuf, rb9, irq, pe, fe} !== {e_buf, e_b9, e_irq, e_pe, e_fe}) begin
        n_bad++;
        $display("FAIL %s (R10/R11 per field): got buf=%h b9=%b irq=%b pe=%b fe=%b, expected buf=%h b9=%b irq=%b pe=%b fe=%b",
                 cur_req, rbuf, rb9, irq, pe, fe, e_buf, e_b9, e_irq, e_pe, e_fe);
      end
    end
  end

  task automatic next_tick();
    do @(posedge clk); while (tick !== 1'b1);
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) next_tick();
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic s1,
                      input logic s2, input string req);
    logic [11:0] fr;
    int nb;
    logic keep, xpe, xfe;
    fr   = {s2, s1, b9, d, 1'b0};
    nb   = two ? 12 : 11;
    xfe  = !s1 || (two && !s2);
    keep = (mode == 3'b100) ? (b9 && !xfe) : 1'b1;
    xpe  = (mode == 3'b111) && (b9 != ^d);
    cur_req = req;
    next_tick();
    @(negedge clk) rxd = fr[0];
    for (int i = 1; i <= 16 * nb; i++) begin
      next_tick();
      if (i == 9 + 16 * (nb - 1) && keep) begin
        e_buf = d; e_b9 = b9; e_pe = xpe; e_fe = xfe; e_irq = 1'b1;
        @(posedge clk);
        e_irq = 1'b0;
      end
      if (i % 16 == 0 && i < 16 * nb) begin
        @(negedge clk) rxd = fr[i / 16];
      end
    end
    @(negedge clk) rxd = 1'b1;
    idle_ticks(32);
  endtask

  task automatic glitch();
    cur_req = "R3";
    next_tick();
    @(negedge clk) rxd = 1'b0;
    idle_ticks(4);
    @(negedge clk) rxd = 1'b1;
    idle_ticks(32);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    n_cmp++;
    if ({rbuf, rb9, irq, pe, fe} !== 12'h000) begin
      n_bad++;
      $display("FAIL R1: got %h expected 000", {rbuf, rb9, irq, pe, fe});
    end
    checking = 1'b1;
    idle_ticks(8);

    mode = 3'b101;
    send(8'hA5, 1'b0, 1'b1, 1'b1, "R2");
    send(8'h3C, 1'b1, 1'b1, 1'b1, "R2");
    send(8'h01, 1'b0, 1'b1, 1'b1, "R11");
    glitch();
    send(8'h81, 1'b0, 1'b1, 1'b1, "R3");

    mode = 3'b100;
    idle_ticks(4);
    send(8'h12, 1'b1, 1'b1, 1'b1, "R4");
    send(8'h77, 1'b0, 1'b1, 1'b1, "R5");
    send(8'hEE, 1'b0, 1'b0, 1'b1, "R5");
    send(8'h55, 1'b1, 1'b0, 1'b1, "R8");
    send(8'h34, 1'b1, 1'b1, 1'b1, "R4");

    mode = 3'b101;
    idle_ticks(4);
    send(8'h77, 1'b0, 1'b1, 1'b1, "R6");
    send(8'h00, 1'b0, 1'b1, 1'b1, "R6");

    mode = 3'b111;
    idle_ticks(4);
    send(8'h03, 1'b0, 1'b1, 1'b1, "R7");
    send(8'h07, 1'b0, 1'b1, 1'b1, "R7");
    send(8'h07, 1'b1, 1'b1, 1'b1, "R7");
    send(8'hF0, 1'b0, 1'b0, 1'b1, "R8");

    mode = 3'b101;
    idle_ticks(4);
    send(8'h5A, 1'b1, 1'b0, 1'b1, "R8");

    two = 1'b1;
    idle_ticks(4);
    send(8'hC3, 1'b0, 1'b1, 1'b0, "R9");
    send(8'h96, 1'b1, 1'b1, 1'b1, "R9");
    mode = 3'b100;
    idle_ticks(4);
    send(8'h44, 1'b1, 1'b1, 1'b0, "R9");
    send(8'h45, 1'b1, 1'b1, 1'b1, "R9");

    checking = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (%s): got hung run, expected completion", cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule